// File: doc/BRIEF.md
# Oversampling Serial Receiver with Wakeup

This block is the receive half of an asynchronous serial port. A one-cycle tick arrives at sixteen times the bit rate. On each tick the receiver looks at the line, finds the falling edge that opens a start bit, and then takes three samples around the middle of every bit. A majority of the three decides the bit value. Any disagreement among the three samples marks the frame as noisy. A frame has one start bit, eight or nine data bits sent least-significant first, and one stop bit. Parity, when enabled, takes the last data bit of the frame.

When a frame completes, the assembled word is presented together with a one-cycle strobe, and the noise, framing and parity indications are refreshed in that same cycle. An idle detector counts ticks of continuous high line. In short mode it starts counting at the first high tick. In long mode it counts only after a stop bit has been sampled. The receiver-active flag follows the line from the first possible start bit until the selected idle condition is detected.

A wakeup mode lets a node on a shared line ignore traffic meant for others. In this mode no frame is delivered and no status changes until the node is woken, either by an idle line or by a frame whose last data bit is set. Waking clears the mode.

Top module: `osr_receiver`

## Requirements
- R1: After reset, `rxWord` is 0, `wordStrobe`, `noiseErr`, `frameErr`, `parityErr`, `rxActive`, `idleSeen` and `asleep` are all 0.
- R2: A frame is one low start bit, then 8 data bits (`cfgNineBit`=0) or 9 data bits (`cfgNineBit`=1) sent LSB first, then one stop bit. Each frame received while enabled and awake gives exactly one single-cycle `wordStrobe`. In 8-bit mode `rxWord[8]` reads 0.
- R3: Ticks are counted from the tick on which a low line is first seen in hunt (tick 0). Each bit is sampled at ticks 7, 8 and 9 of its 16-tick period, and the majority value is used. One dissenting sample on the start bit, a data bit or the stop bit leaves the value unchanged and sets `noiseErr` for that frame.
- R4: A start bit whose majority vote is high is rejected. The receiver goes back to hunting with no strobe, and the rejected start leaves no noise indication on the next frame.
- R5: With `cfgParityEn`=1, the last data bit is the parity bit. `parityErr` is set when the XOR of all received data bits is 1 with `cfgParityOdd`=0 (even), or 0 with `cfgParityOdd`=1 (odd). With parity disabled, `parityErr` stays 0.
- R6: A stop bit whose vote is low sets `frameErr`. An all-zero break frame is still delivered with a strobe, word 0 and `frameErr`=1.
- R7: `rxWord`, `noiseErr`, `frameErr` and `parityErr` change only in the cycle where `wordStrobe` is high.
- R8: An idle line is 160 ticks (8-bit mode) or 176 ticks (9-bit mode) of continuous high line. In short mode (`cfgLongIdle`=0) counting starts at the first high tick, even inside a frame. In long mode it starts on the tick after the stop bit's third sample. `idleSeen` pulses one cycle after the completing tick, at most once per delivered frame, and never in the same cycle as `wordStrobe`.
- R9: `rxActive` rises on the tick that sees a possible start bit, stays high for the whole frame, and falls when the idle condition is detected.
- R10: A `wakeSet` pulse sets `asleep`. While asleep with `cfgWakeAddr`=0, frames give no strobe and no status change. The next idle detection clears `asleep` without pulsing `idleSeen`, and later frames are delivered.
- R11: While asleep with `cfgWakeAddr`=1, a frame whose last data bit (bit 7 or bit 8) is 0 is ignored and idle does not wake. A frame whose last data bit is 1 clears `asleep` and is itself delivered.
- R12: While `rxEnable` is 0, no frame is received, `rxActive` is 0 and `wordStrobe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxEnable | input | 1 | Receiver enable |
| cfgNineBit | input | 1 | 1: nine data bits, 0: eight |
| cfgParityEn | input | 1 | Last data bit is parity |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even |
| cfgLongIdle | input | 1 | 1: idle counted only after a stop bit |
| cfgWakeAddr | input | 1 | Wakeup source, 1: address mark, 0: idle line |
| wakeSet | input | 1 | Pulse that enters wakeup mode |
| rxWord | output | 9 | Last delivered word |
| wordStrobe | output | 1 | One-cycle pulse when a word is delivered |
| noiseErr | output | 1 | Sample disagreement in last word |
| frameErr | output | 1 | Low stop bit in last word |
| parityErr | output | 1 | Parity mismatch in last word |
| rxActive | output | 1 | Receiver busy since a possible start bit |
| idleSeen | output | 1 | One-cycle pulse on idle-line detection |
| asleep | output | 1 | Wakeup mode in force |

## Verification
The hardest situations to reach from the ports are the exact idle instants and the wakeup paths, because both depend on where the count of high ticks began. The bench drives the line one tick at a time and numbers every tick. It can then compare the tick on which `idleSeen` appears with the offset computed for each of the four combinations of word length and idle type. Noise is forced by flipping only the middle of the three sample ticks of a chosen bit. Rejected starts are made with low pulses that end before the sample window, after which a clean frame must still assemble correctly.

// File: rtl/osr_pkg.sv
package osr_pkg;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;       // 16x tick this cycle
    logic sampleNow;  // take one of the three mid-bit samples
    logic startOk;    // start bit accepted, clear assembly
    logic dataBit;    // shift voted bit into the word
    logic deliver;    // publish word and error flags
    logic countIdle;  // idle counter allowed to run
  } rxStrobes_t;

endpackage

// File: rtl/osr_datapath.sv
module osr_datapath
  import osr_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              cfgNineBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  rxStrobes_t        strb,
  output logic              vote,
  output logic              lastBit,
  output logic              idleHit,
  output logic [DATA_W:0]   rxWord,
  output logic              wordStrobe,
  output logic              noiseErr,
  output logic              frameErr,
  output logic              parityErr
);

  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2((DATA_W + 3) * OVS + 1);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'((DATA_W + 2) * OVS);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'((DATA_W + 3) * OVS);

  logic [1:0]        sampPair;
  logic              disagree;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] assembled;
  logic              noiseAcc;
  logic [CNT_W-1:0]  idleCnt;
  logic [CNT_W-1:0]  idleLim;

  // first two samples held, third taken live on the deciding tick
  always_ff @(posedge clk) begin
    if (!rstN) sampPair <= '0;
    else if (strb.sampleNow) sampPair <= {sampPair[0], rxLine};
  end

  assign vote = (sampPair[1] & sampPair[0]) | (sampPair[1] & rxLine) | (sampPair[0] & rxLine);
  assign disagree = !((sampPair[1] == sampPair[0]) && (sampPair[0] == rxLine));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      noiseAcc <= 1'b0;
    end else if (strb.startOk) begin
      shiftReg <= '0;
      noiseAcc <= disagree;
    end else if (strb.dataBit) begin
      shiftReg <= {vote, shiftReg[WORD_W-1:1]};
      noiseAcc <= noiseAcc | disagree;
    end
  end

  assign assembled = cfgNineBit ? shiftReg : {1'b0, shiftReg[WORD_W-1:1]};
  assign lastBit   = shiftReg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWord     <= '0;
      noiseErr   <= 1'b0;
      frameErr   <= 1'b0;
      parityErr  <= 1'b0;
      wordStrobe <= 1'b0;
    end else begin
      wordStrobe <= strb.deliver;
      if (strb.deliver) begin
        rxWord    <= assembled;
        noiseErr  <= noiseAcc | disagree;
        frameErr  <= ~vote;
        parityErr <= cfgParityEn & ((^assembled) ^ cfgParityOdd);
      end
    end
  end

  // idle-line counter, saturating at the frame length
  assign idleLim = cfgNineBit ? LIM_LONG : LIM_SHORT;

  always_ff @(posedge clk) begin
    if (!rstN || !strb.countIdle) idleCnt <= '0;
    else if (strb.tick) begin
      if (!rxLine) idleCnt <= '0;
      else if (idleCnt != idleLim) idleCnt <= idleCnt + 1'b1;
    end
  end

  assign idleHit = strb.countIdle && strb.tick && rxLine && (idleCnt == idleLim - 1'b1);

  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |=> !wordStrobe);

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wordStrobe |-> $stable({rxWord, noiseErr, frameErr, parityErr}));

endmodule

// File: rtl/osr_control.sv
module osr_control
  import osr_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       tick16,
  input  logic       rxEnable,
  input  logic       cfgNineBit,
  input  logic       cfgLongIdle,
  input  logic       cfgWakeAddr,
  input  logic       wakeSet,
  input  logic       vote,
  input  logic       lastBit,
  input  logic       idleHit,
  output rxStrobes_t strb,
  output logic       rxActive,
  output logic       idleSeen,
  output logic       asleep
);

  localparam int PH_W = $clog2(OVS);
  localparam int BI_W = $clog2(DATA_W + 1);
  localparam logic [PH_W-1:0] PH_FIRST = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(OVS / 2 + 1);
  localparam logic [PH_W-1:0] PH_WRAP  = PH_W'(OVS - 1);

  rxState_t        state;
  logic [PH_W-1:0] phase;
  logic [BI_W-1:0] bitIdx;
  logic [BI_W-1:0] lastIdx;
  logic            wakeMode;
  logic            armed;
  logic            huntLow, inFrame, bitDone, stopBit, addrWake, idleNext;

  assign inFrame  = (state != RX_HUNT);
  assign huntLow  = rxEnable && tick16 && !inFrame && !rxLine;
  assign bitDone  = tick16 && inFrame && (phase == PH_LAST);
  assign stopBit  = bitDone && (state == RX_STOP);
  assign addrWake = stopBit && wakeMode && cfgWakeAddr && lastBit;
  assign lastIdx  = cfgNineBit ? BI_W'(DATA_W) : BI_W'(DATA_W - 1);
  assign idleNext = idleHit && armed && !wakeMode;

  always_comb begin
    strb.tick      = tick16;
    strb.sampleNow = tick16 && inFrame && (phase >= PH_FIRST) && (phase <= PH_LAST);
    strb.startOk   = bitDone && (state == RX_START) && !vote;
    strb.dataBit   = bitDone && (state == RX_DATA);
    strb.deliver   = stopBit && rxEnable && (!wakeMode || addrWake);
    strb.countIdle = rxEnable && (!cfgLongIdle || !inFrame);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state  <= RX_HUNT;
      phase  <= '0;
      bitIdx <= '0;
    end else if (huntLow) begin
      state <= RX_START;
      phase <= PH_W'(1);
    end else if (tick16 && inFrame) begin
      phase <= (phase == PH_WRAP) ? '0 : phase + 1'b1;
      if (bitDone) begin
        case (state)
          RX_START: begin
            state  <= vote ? RX_HUNT : RX_DATA;
            bitIdx <= '0;
          end
          RX_DATA: begin
            if (bitIdx == lastIdx) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      wakeMode <= 1'b0;
      armed    <= 1'b0;
      idleSeen <= 1'b0;
    end else begin
      if (!rxEnable)    rxActive <= 1'b0;
      else if (huntLow) rxActive <= 1'b1;
      else if (idleHit) rxActive <= 1'b0;

      if (wakeSet) wakeMode <= 1'b1;
      else if (addrWake || (idleHit && !cfgWakeAddr)) wakeMode <= 1'b0;

      if (strb.deliver) armed <= 1'b1;
      else if (idleNext) armed <= 1'b0;

      idleSeen <= idleNext;
    end
  end

  assign asleep = wakeMode;

  p_frame_active_r9: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |-> rxActive);

endmodule

// File: rtl/osr_receiver.sv
module osr_receiver
  import osr_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxLine,
  input  logic            tick16,
  input  logic            rxEnable,
  input  logic            cfgNineBit,
  input  logic            cfgParityEn,
  input  logic            cfgParityOdd,
  input  logic            cfgLongIdle,
  input  logic            cfgWakeAddr,
  input  logic            wakeSet,
  output logic [DATA_W:0] rxWord,
  output logic            wordStrobe,
  output logic            noiseErr,
  output logic            frameErr,
  output logic            parityErr,
  output logic            rxActive,
  output logic            idleSeen,
  output logic            asleep
);

  rxStrobes_t strb;
  logic       vote, lastBit, idleHit;

  osr_control #(.OVS(OVS), .DATA_W(DATA_W)) i_control (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .tick16(tick16),
    .rxEnable(rxEnable), .cfgNineBit(cfgNineBit), .cfgLongIdle(cfgLongIdle),
    .cfgWakeAddr(cfgWakeAddr), .wakeSet(wakeSet), .vote(vote),
    .lastBit(lastBit), .idleHit(idleHit), .strb(strb),
    .rxActive(rxActive), .idleSeen(idleSeen), .asleep(asleep)
  );

  osr_datapath #(.OVS(OVS), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .cfgNineBit(cfgNineBit),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .strb(strb),
    .vote(vote), .lastBit(lastBit), .idleHit(idleHit), .rxWord(rxWord),
    .wordStrobe(wordStrobe), .noiseErr(noiseErr), .frameErr(frameErr),
    .parityErr(parityErr)
  );

  p_idle_apart_from_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |-> !idleSeen);

  p_quiet_when_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rxEnable) |-> !wordStrobe);

endmodule

// File: tb/test_osr_receiver.sv
module test_osr_receiver;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1, tick16 = 1'b0, rxEnable = 1'b1;
  logic       cfgNineBit = 1'b0, cfgParityEn = 1'b0, cfgParityOdd = 1'b0;
  logic       cfgLongIdle = 1'b0, cfgWakeAddr = 1'b0, wakeSet = 1'b0;
  logic [8:0] rxWord;
  logic       wordStrobe, noiseErr, frameErr, parityErr, rxActive, idleSeen, asleep;

  int nVec = 0, nBad = 0, tickNum = 0;
  int strobeCnt = 0, idleCount = 0, idleAt = -1;
  logic [8:0] capWord = '0;
  logic capN = 1'b0, capF = 1'b0, capP = 1'b0;

  always #4 clk = ~clk;

  osr_receiver i_osr_receiver (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .tick16(tick16), .rxEnable(rxEnable),
    .cfgNineBit(cfgNineBit), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgLongIdle(cfgLongIdle), .cfgWakeAddr(cfgWakeAddr), .wakeSet(wakeSet),
    .rxWord(rxWord), .wordStrobe(wordStrobe), .noiseErr(noiseErr), .frameErr(frameErr),
    .parityErr(parityErr), .rxActive(rxActive), .idleSeen(idleSeen), .asleep(asleep)
  );

  always @(negedge clk) begin
    if (wordStrobe) begin
      strobeCnt++;
      capWord = rxWord; capN = noiseErr; capF = frameErr; capP = parityErr;
    end
    if (idleSeen) begin
      idleCount++;
      idleAt = tickNum;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    nVec++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic oneTick(input logic v);
    @(negedge clk);
    tickNum++;
    rxLine = v;
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic holdLine(input logic v, input int n);
    for (int i = 0; i < n; i++) oneTick(v);
  endtask

  // noisyBit: -1 none, 0 start, 1..n data, n+1 stop; flips only sample tick 8
  task automatic sendFrame(input logic [8:0] bits, input logic stopV, input int noisyBit);
    int nb;
    logic val, v;
    nb = cfgNineBit ? 9 : 8;
    for (int b = 0; b <= nb + 1; b++) begin
      val = (b == 0) ? 1'b0 : (b <= nb) ? bits[b-1] : stopV;
      for (int k = 0; k < 16; k++) begin
        v = (k == 8 && b == noisyBit) ? ~val : val;
        if (b == nb + 1 && !stopV && k > 9) v = 1'b1;
        oneTick(v);
      end
    end
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeSet = 1'b1;
    @(negedge clk); wakeSet = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int sc, ic, t0, noisy, nb, expT;
    logic [8:0] pat, expW;
    logic stopV;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rxWord", rxWord, 0);
    check("R1 strobe/flags", {wordStrobe, noiseErr, frameErr, parityErr}, 0);
    check("R1 rxActive/idleSeen/asleep", {rxActive, idleSeen, asleep}, 0);
    holdLine(1'b1, 20);

    // R2 R3 R5 R6 sweep over word length, parity enable and parity sense
    for (int cfg = 0; cfg < 8; cfg++) begin
      cfgNineBit = cfg[0]; cfgParityEn = cfg[1]; cfgParityOdd = cfg[2];
      nb = cfgNineBit ? 9 : 8;
      for (int i = 0; i < 24; i++) begin
        pat = (i == 0) ? 9'h000 : (i == 1) ? 9'h1FF : 9'((i * 157 + cfg * 31) % 512);
        stopV = (i % 7 != 3) && (i != 0);
        noisy = (i % 5 == 2) ? (i % (nb + 2)) : -1;
        sc = strobeCnt;
        sendFrame(pat, stopV, noisy);
        holdLine(1'b1, 20);
        expW = cfgNineBit ? pat : {1'b0, pat[7:0]};
        check("R2 one strobe per frame", strobeCnt, sc + 1);
        check("R2 word", capWord, expW);
        check("R6 framing", capF, !stopV);
        check("R3 noise vote", capN, noisy >= 0);
        check("R5 parity", capP, cfgParityEn & ((^expW) ^ cfgParityOdd));
      end
    end

    // R4 rejected starts
    cfgNineBit = 1'b0; cfgParityEn = 1'b0; cfgParityOdd = 1'b0;
    sendFrame(9'h0C3, 1'b1, 3);
    holdLine(1'b1, 20);
    sc = strobeCnt;
    holdLine(1'b0, 2);
    holdLine(1'b1, 30);
    holdLine(1'b0, 8);
    holdLine(1'b1, 30);
    check("R4 no strobe on rejected start", strobeCnt, sc);
    check("R7 word held after rejects", rxWord, 9'h0C3);
    check("R7 noise flag held after rejects", noiseErr, 1);
    sendFrame(9'h05A, 1'b1, -1);
    holdLine(1'b1, 20);
    check("R4 frame after reject", capWord, 9'h05A);
    check("R4 no noise left over", capN, 0);

    // R8 R9 idle timing for each word length and idle type
    for (int m = 0; m < 4; m++) begin
      cfgNineBit = m[0]; cfgLongIdle = m[1];
      expT = cfgNineBit ? (cfgLongIdle ? 345 : 191) : (cfgLongIdle ? 313 : 175);
      ic = idleCount;
      t0 = tickNum + 1;
      sendFrame(9'h1FF, 1'b1, -1);
      check("R9 active after frame", rxActive, 1);
      holdLine(1'b1, 400);
      check("R8 one idle pulse", idleCount, ic + 1);
      check("R8 idle tick offset", idleAt - t0, expT);
      check("R9 active cleared by idle", rxActive, 0);
      holdLine(1'b0, 1);
      check("R9 active on possible start", rxActive, 1);
      holdLine(1'b1, 400);
      check("R8 no second idle without frame", idleCount, ic + 1);
    end
    cfgLongIdle = 1'b0;

    // R10 wake on idle line
    cfgNineBit = 1'b0; cfgWakeAddr = 1'b0;
    pulseWake();
    check("R10 asleep set", asleep, 1);
    sc = strobeCnt; ic = idleCount;
    sendFrame(9'h00F, 1'b0, 2);
    holdLine(1'b1, 20);
    check("R10 frame ignored", strobeCnt, sc);
    check("R10 flags untouched", {noiseErr, frameErr}, 0);
    check("R10 still asleep", asleep, 1);
    holdLine(1'b1, 200);
    check("R10 idle wakes", asleep, 0);
    check("R10 no idle pulse on wake", idleCount, ic);
    sendFrame(9'h03C, 1'b1, -1);
    holdLine(1'b1, 20);
    check("R10 delivered after wake", capWord, 9'h03C);

    // R11 wake on address mark, nine and eight bits
    cfgWakeAddr = 1'b1; cfgNineBit = 1'b1;
    pulseWake();
    sc = strobeCnt;
    sendFrame(9'h0AA, 1'b1, -1);
    holdLine(1'b1, 250);
    check("R11 low mark ignored", strobeCnt, sc);
    check("R11 idle does not wake", asleep, 1);
    sendFrame(9'h1AA, 1'b1, -1);
    holdLine(1'b1, 20);
    check("R11 mark delivered", strobeCnt, sc + 1);
    check("R11 mark word", capWord, 9'h1AA);
    check("R11 woken", asleep, 0);
    cfgNineBit = 1'b0;
    pulseWake();
    sc = strobeCnt;
    sendFrame(9'h07F, 1'b1, -1);
    holdLine(1'b1, 20);
    check("R11 8-bit low mark ignored", strobeCnt, sc);
    sendFrame(9'h080, 1'b1, -1);
    holdLine(1'b1, 20);
    check("R11 8-bit mark word", capWord, 9'h080);
    check("R11 8-bit woken", asleep, 0);
    cfgWakeAddr = 1'b0;

    // R12 receiver disabled
    @(negedge clk); rxEnable = 1'b0;
    sc = strobeCnt;
    sendFrame(9'h055, 1'b1, -1);
    check("R12 inactive while off", rxActive, 0);
    holdLine(1'b1, 20);
    check("R12 nothing received while off", strobeCnt, sc);
    @(negedge clk); rxEnable = 1'b1;
    holdLine(1'b1, 20);
    sendFrame(9'h066, 1'b1, -1);
    holdLine(1'b1, 20);
    check("R12 receives after enable", capWord, 9'h066);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule